// File: doc/BRIEF.md
# Indirect CSR Window Sequencer

This block turns one indirect register access into the series of narrow accesses that a per-interrupt controller's register file needs. An access is a select index, a data-register index, a read/write flag and a 32-bit word. The controller keeps four bytes per interrupt at a stride of four bytes from byte address 0x1000: pending flag in lane 0, enable flag in lane 1, attribute in lane 2, control in lane 3. Its trigger registers are word-wide and sit in a separate word space.

The sequencer works out which range the select falls in. For the per-interrupt byte range it runs four byte accesses, one for each of four neighbouring interrupts, and packs the bytes into one word. For the flag range it runs thirty-two byte accesses that each carry a single flag in bit 0. For the trigger range it makes one word access. Selects and indexes outside the window make no access at all. The sequencer handles one access at a time and pulses done when that access is over. Read data is valid in the done cycle.

Top module: `csr_window_seq`

## Requirements
- R1: While reset is held and on the first cycle after it, busy and done are low, and neither the byte port enable nor the word port enable is asserted.
- R2: A read with select S in 0x000..0x3FF reads byte addresses A, A+4, A+8 and A+12 on successive cycles, where A = 0x1000 + 16*S + 3 for index 0 (control) and + 2 for index 1 (attribute). The byte from A+4k is returned in rdata bits 8k+7:8k.
- R3: A write with select S in 0x000..0x3FF makes four byte writes on successive cycles, to the addresses of R2. Write k carries wdata bits 8k+7:8k.
- R4: A read with select S in 0x400..0x47F reads the 32 byte addresses 0x1000 + 128*(S-0x400) + 4b + L for b = 0..31, in increasing b order, where L is 0 (pending) for index 0 and 1 (enable) for index 1. Bit 0 of byte b is returned in rdata bit b.
- R5: A write with select S in 0x400..0x47F makes byte writes to the 32 addresses of R4. Byte b is wdata bit b in bit 0, with bits 7:1 zero.
- R6: With index 0, a select S in 0x480..0x49F makes exactly one word-port access at word address 0x40 + (S-0x480), with no byte access. A read returns the word. A write drives wdata.
- R7: With index 1, a select in 0x480..0x49F makes no access, and a read returns zero.
- R8: A select of 0x4A0 or above, or an index of 2 or 3, makes no access on either port, and a read returns zero.
- R9: A request is taken only while busy is low. busy stays high from acceptance through the done cycle. Request inputs that change or stay asserted while busy are ignored.
- R10: done is a one-cycle pulse. Counting clock edges after the accepting edge, done is visible after 5 edges for the byte range, 33 for the flag range, 2 for a trigger access, and 1 for an access that makes none. A write returns rdata zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_sel | input | 12 | Select index |
| req_idx | input | 2 | Data-register index |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write word |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access complete pulse |
| rdata | output | 32 | Read word, valid with done |
| bp_en | output | 1 | Byte port access strobe |
| bp_we | output | 1 | Byte port write |
| bp_addr | output | 16 | Byte port address |
| bp_wdata | output | 8 | Byte port write data |
| bp_rdata | input | 8 | Byte port read data, combinational |
| wp_en | output | 1 | Word port access strobe |
| wp_we | output | 1 | Word port write |
| wp_addr | output | 16 | Word port address |
| wp_wdata | output | 32 | Word port write data |
| wp_rdata | input | 32 | Word port read data, combinational |

## Verification
The bench builds the block with its default geometry: a 12-bit select, a 2-bit index and a 16-bit byte address. That makes every range edge reachable, including the first and last selects of each range, the reserved select 0x4A0, the top select 0xFFF and the two illegal indexes. The register file is a sparse bench memory. Every written location can therefore be read back through the block, so the lane and bit packing is checked in both directions as well as against the access log.

// File: rtl/csr_window_pkg.sv
package csr_window_pkg;

    // geometry of the window
    localparam int unsigned SEL_W   = 12;
    localparam int unsigned IDX_W   = 2;
    localparam int unsigned ADDR_W  = 16;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned BYTE_W  = 8;

    localparam int unsigned LANE_STEPS = WORD_W / BYTE_W;
    localparam int unsigned FLAG_STEPS = WORD_W;
    localparam int unsigned STEP_W     = $clog2(FLAG_STEPS) + 1;
    localparam int unsigned LANE_IDX_W = $clog2(LANE_STEPS);
    localparam int unsigned FLAG_IDX_W = $clog2(FLAG_STEPS);
    localparam int unsigned BYTE_SH    = $clog2(BYTE_W);

    // select ranges (order is behaviour: ranges are contiguous)
    localparam logic [SEL_W-1:0] SEL_FLAG_LO  = SEL_W'(12'h400);
    localparam logic [SEL_W-1:0] SEL_TRIG_LO  = SEL_W'(12'h480);
    localparam logic [SEL_W-1:0] SEL_TRIG_END = SEL_W'(12'h4A0);

    // register file layout
    localparam logic [ADDR_W-1:0] IRQ_BASE    = ADDR_W'(16'h1000);
    localparam logic [ADDR_W-1:0] TRIG_BASE   = ADDR_W'(16'h0040);
    localparam int unsigned       IRQ_STRIDE_SH = 2;   // 4 bytes per interrupt
    localparam int unsigned       GRP_LANE_SH   = 4;   // 4 interrupts per select
    localparam int unsigned       GRP_FLAG_SH   = 7;   // 32 interrupts per select
    localparam logic [ADDR_W-1:0] LANE_PEND   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] LANE_ENA    = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] LANE_ATTR   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] LANE_CTRL   = ADDR_W'(3);

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LANES = 2'd1,
        OP_FLAGS = 2'd2,
        OP_WORD  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } state_e;

    typedef struct packed {
        op_e               op;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [STEP_W-1:0] steps;
    } plan_t;

    function automatic logic uses_bytes(input op_e op);
        return (op == OP_LANES) || (op == OP_FLAGS);
    endfunction

endpackage

// File: rtl/csr_window_decode.sv
module csr_window_decode
    import csr_window_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr,
    output plan_t            plan
);

    logic idx_ok;
    logic in_lanes;
    logic in_flags;
    logic in_trig;

    assign idx_ok   = (idx < IDX_W'(2));
    assign in_lanes = (sel < SEL_FLAG_LO);
    assign in_flags = (sel >= SEL_FLAG_LO) && (sel < SEL_TRIG_LO);
    assign in_trig  = (sel >= SEL_TRIG_LO) && (sel < SEL_TRIG_END);

    always_comb begin
        plan       = '0;
        plan.op    = OP_NONE;
        plan.wr    = wr;
        if (idx_ok) begin
            if (in_lanes) begin
                plan.op    = OP_LANES;
                plan.addr  = IRQ_BASE + (ADDR_W'(sel) << GRP_LANE_SH)
                           + (idx[0] ? LANE_ATTR : LANE_CTRL);
                plan.steps = STEP_W'(LANE_STEPS);
            end else if (in_flags) begin
                plan.op    = OP_FLAGS;
                plan.addr  = IRQ_BASE + (ADDR_W'(sel - SEL_FLAG_LO) << GRP_FLAG_SH)
                           + (idx[0] ? LANE_ENA : LANE_PEND);
                plan.steps = STEP_W'(FLAG_STEPS);
            end else if (in_trig && !idx[0]) begin
                plan.op    = OP_WORD;
                plan.addr  = TRIG_BASE + ADDR_W'(sel - SEL_TRIG_LO);
                plan.steps = STEP_W'(1);
            end
        end
    end

endmodule

// File: rtl/csr_window_ctrl.sv
module csr_window_ctrl
    import csr_window_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  plan_t             plan_d,
    output plan_t             plan_q,
    output logic [STEP_W-1:0] step_q,
    output logic              accept,
    output logic              active,
    output logic              busy,
    output logic              done
);

    state_e state_q;
    logic   last_step;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign active    = (state_q == ST_RUN);
    assign busy      = (state_q != ST_IDLE);
    assign done      = (state_q == ST_DONE);
    assign last_step = (step_q == plan_q.steps - STEP_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            plan_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        plan_q  <= plan_d;
                        step_q  <= '0;
                        state_q <= (plan_d.op == OP_NONE) ? ST_DONE : ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (last_step) begin
                        state_q <= ST_DONE;
                    end else begin
                        step_q <= step_q + STEP_W'(1);
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!busy && !done)); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst) (busy && !done) |=> busy); // R9

endmodule

// File: rtl/csr_window_pack.sv
module csr_window_pack
    import csr_window_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic [WORD_W-1:0] req_wdata,
    input  op_e               op,
    input  logic              wr,
    input  logic              active,
    input  logic [STEP_W-1:0] step_q,
    input  logic [BYTE_W-1:0] bp_rdata,
    input  logic [WORD_W-1:0] wp_rdata,
    output logic [BYTE_W-1:0] byte_wdata,
    output logic [WORD_W-1:0] word_wdata,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0]     wdata_q;
    logic [WORD_W-1:0]     rbuf_q;
    logic [LANE_IDX_W-1:0] lane_k;
    logic [FLAG_IDX_W-1:0] flag_b;
    logic [FLAG_IDX_W-1:0] lane_lsb;

    assign lane_k   = step_q[LANE_IDX_W-1:0];
    assign flag_b   = step_q[FLAG_IDX_W-1:0];
    assign lane_lsb = FLAG_IDX_W'({lane_k, BYTE_SH'(0)});

    always_comb begin
        case (op)
            OP_LANES: byte_wdata = wdata_q[lane_lsb +: BYTE_W];
            OP_FLAGS: byte_wdata = {{(BYTE_W-1){1'b0}}, wdata_q[flag_b]};
            default:  byte_wdata = '0;
        endcase
    end

    assign word_wdata = wdata_q;
    assign rdata      = rbuf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
            rbuf_q  <= '0;
        end else if (accept) begin
            wdata_q <= req_wdata;
            rbuf_q  <= '0;
        end else if (active && !wr) begin
            case (op)
                OP_LANES: rbuf_q[lane_lsb +: BYTE_W] <= bp_rdata;
                OP_FLAGS: rbuf_q[flag_b]             <= bp_rdata[0];
                OP_WORD:  rbuf_q                     <= wp_rdata;
                default:  rbuf_q                     <= rbuf_q;
            endcase
        end
    end

endmodule

// File: rtl/csr_window_seq.sv
module csr_window_seq
    import csr_window_pkg::*;
#(
    parameter int unsigned P_SEL_W  = SEL_W,
    parameter int unsigned P_IDX_W  = IDX_W,
    parameter int unsigned P_ADDR_W = ADDR_W,
    parameter int unsigned P_WORD_W = WORD_W,
    parameter int unsigned P_BYTE_W = BYTE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [P_SEL_W-1:0]  req_sel,
    input  logic [P_IDX_W-1:0]  req_idx,
    input  logic                req_write,
    input  logic [P_WORD_W-1:0] req_wdata,
    output logic                busy,
    output logic                done,
    output logic [P_WORD_W-1:0] rdata,
    output logic                bp_en,
    output logic                bp_we,
    output logic [P_ADDR_W-1:0] bp_addr,
    output logic [P_BYTE_W-1:0] bp_wdata,
    input  logic [P_BYTE_W-1:0] bp_rdata,
    output logic                wp_en,
    output logic                wp_we,
    output logic [P_ADDR_W-1:0] wp_addr,
    output logic [P_WORD_W-1:0] wp_wdata,
    input  logic [P_WORD_W-1:0] wp_rdata
);

    plan_t             plan_d;
    plan_t             plan_q;
    logic [STEP_W-1:0] step_q;
    logic              accept;
    logic              active;

    csr_window_decode u_decode (
        .sel  (SEL_W'(req_sel)),
        .idx  (IDX_W'(req_idx)),
        .wr   (req_write),
        .plan (plan_d)
    );

    csr_window_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .plan_d    (plan_d),
        .plan_q    (plan_q),
        .step_q    (step_q),
        .accept    (accept),
        .active    (active),
        .busy      (busy),
        .done      (done)
    );

    logic [BYTE_W-1:0] byte_wdata;
    logic [WORD_W-1:0] word_wdata;
    logic [WORD_W-1:0] rdata_int;

    csr_window_pack u_pack (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .req_wdata  (WORD_W'(req_wdata)),
        .op         (plan_q.op),
        .wr         (plan_q.wr),
        .active     (active),
        .step_q     (step_q),
        .bp_rdata   (BYTE_W'(bp_rdata)),
        .wp_rdata   (WORD_W'(wp_rdata)),
        .byte_wdata (byte_wdata),
        .word_wdata (word_wdata),
        .rdata      (rdata_int)
    );

    assign bp_en    = active && uses_bytes(plan_q.op);
    assign bp_we    = bp_en && plan_q.wr;
    assign bp_addr  = P_ADDR_W'(plan_q.addr + (ADDR_W'(step_q) << IRQ_STRIDE_SH));
    assign bp_wdata = P_BYTE_W'(byte_wdata);
    assign wp_en    = active && (plan_q.op == OP_WORD);
    assign wp_we    = wp_en && plan_q.wr;
    assign wp_addr  = P_ADDR_W'(plan_q.addr);
    assign wp_wdata = P_WORD_W'(word_wdata);
    assign rdata    = P_WORD_W'(rdata_int);

    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst) !busy |-> (!bp_en && !wp_en)); // R9
    AST_ONE_PORT: assert property (@(posedge clk) disable iff (rst) !(bp_en && wp_en)); // R6
    AST_BYTE_STRIDE: assert property (@(posedge clk) disable iff (rst) (bp_en && $past(bp_en)) |-> (bp_addr == $past(bp_addr) + P_ADDR_W'(4))); // R3
    AST_DONE_NO_ACCESS: assert property (@(posedge clk) disable iff (rst) done |-> (!bp_en && !wp_en)); // R10

endmodule

// File: tb/csr_window_seq_bench.sv
`timescale 1ns/1ps
module csr_window_seq_bench;

    localparam time CLK_P = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [11:0] req_sel = '0;
    logic [1:0]  req_idx = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        busy, done;
    logic [31:0] rdata;
    logic        bp_en, bp_we;
    logic [15:0] bp_addr;
    logic [7:0]  bp_wdata;
    logic [7:0]  bp_rdata;
    logic        wp_en, wp_we;
    logic [15:0] wp_addr;
    logic [31:0] wp_wdata;
    logic [31:0] wp_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    csr_window_seq u_csr_window_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel),
        .req_idx(req_idx), .req_write(req_write), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rdata(rdata),
        .bp_en(bp_en), .bp_we(bp_we), .bp_addr(bp_addr), .bp_wdata(bp_wdata),
        .bp_rdata(bp_rdata), .wp_en(wp_en), .wp_we(wp_we), .wp_addr(wp_addr),
        .wp_wdata(wp_wdata), .wp_rdata(wp_rdata)
    );

    // sparse register-file model
    logic [7:0]  bmem [int];
    logic [31:0] wmem [int];
    int          mem_gen = 0;

    function automatic logic [7:0] bmem_rd(input logic [15:0] a);
        if (bmem.exists(int'(a))) return bmem[int'(a)];
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    function automatic logic [31:0] wmem_rd(input logic [15:0] a);
        if (wmem.exists(int'(a))) return wmem[int'(a)];
        return {a, ~a} ^ 32'h3C3C_0F0F;
    endfunction

    always @(bp_addr, mem_gen) bp_rdata = bmem_rd(bp_addr);
    always @(wp_addr, mem_gen) wp_rdata = wmem_rd(wp_addr);

    // access log
    int          n_bacc, n_wacc;
    logic [15:0] log_addr [64];
    logic        log_we   [64];
    logic [7:0]  log_data [64];
    logic [15:0] wlog_addr;
    logic        wlog_we;
    logic [31:0] wlog_data;

    always @(posedge clk) begin
        if (bp_en) begin
            if (n_bacc < 64) begin
                log_addr[n_bacc] = bp_addr;
                log_we[n_bacc]   = bp_we;
                log_data[n_bacc] = bp_wdata;
            end
            n_bacc++;
            if (bp_we) begin
                bmem[int'(bp_addr)] = bp_wdata;
                mem_gen++;
            end
        end
        if (wp_en) begin
            wlog_addr = wp_addr;
            wlog_we   = wp_we;
            wlog_data = wp_wdata;
            n_wacc++;
            if (wp_we) begin
                wmem[int'(wp_addr)] = wp_wdata;
                mem_gen++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // kind: 0 none, 1 lanes, 2 flags, 3 word
    function automatic void plan(input logic [11:0] sel, input logic [1:0] idx,
                                 output int kind, output logic [15:0] base, output int steps);
        kind = 0; base = '0; steps = 0;
        if (idx > 2'd1) return;
        if (sel < 12'h400) begin
            kind = 1; steps = 4;
            base = 16'h1000 + 16'(sel) * 16 + (idx == 2'd0 ? 16'd3 : 16'd2);
        end else if (sel < 12'h480) begin
            kind = 2; steps = 32;
            base = 16'h1000 + 16'(sel - 12'h400) * 128 + 16'(idx);
        end else if (sel < 12'h4A0 && idx == 2'd0) begin
            kind = 3; steps = 1;
            base = 16'h0040 + 16'(sel - 12'h480);
        end
    endfunction

    function automatic string req_tag(input int kind, input logic we,
                                      input logic [11:0] sel);
        case (kind)
            1: return we ? "R3" : "R2";
            2: return we ? "R5" : "R4";
            3: return "R6";
            default: return (sel >= 12'h480 && sel < 12'h4A0) ? "R7" : "R8";
        endcase
    endfunction

    task automatic do_txn(input logic [11:0] sel, input logic [1:0] idx, input logic we,
                          input logic [31:0] wd, input bit scramble);
        int kind, steps, n, exp_lat;
        logic [15:0] base;
        logic [31:0] exp_rd;
        string tag;
        bit ok;
        plan(sel, idx, kind, base, steps);
        tag = req_tag(kind, we, sel);
        exp_rd = '0;
        if (!we) begin
            case (kind)
                1: for (int k = 0; k < 4; k++) exp_rd[8*k +: 8] = bmem_rd(base + 16'(4*k));
                2: for (int b = 0; b < 32; b++) exp_rd[b] = bmem_rd(base + 16'(4*b))[0];
                3: exp_rd = wmem_rd(base);
                default: exp_rd = '0;
            endcase
        end
        exp_lat = (kind == 0) ? 1 : steps + 1;
        @(negedge clk);
        n_bacc = 0; n_wacc = 0;
        req_valid = 1'b1; req_sel = sel; req_idx = idx; req_write = we; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        if (scramble) begin
            // R9: keep requesting with other fields while busy
            req_sel = 12'h001; req_idx = 2'd1; req_write = ~we; req_wdata = ~wd;
            chk(busy == 1'b1, "R9", "busy after accept", 32'(busy), 32'd1);
        end else begin
            req_valid = 1'b0;
        end
        n = 1;
        while (!done && n < 100) begin
            @(negedge clk);
            n++;
        end
        req_valid = 1'b0;
        chk(n == exp_lat, "R10", "done latency", 32'(n), 32'(exp_lat));
        chk(rdata == exp_rd, tag, "rdata", rdata, exp_rd);
        if (kind == 1 || kind == 2) begin
            chk(n_bacc == steps && n_wacc == 0, tag, "byte access count",
                32'(n_bacc), 32'(steps));
            ok = 1;
            for (int k = 0; k < steps && k < 64; k++) begin
                if (log_addr[k] != base + 16'(4*k)) ok = 0;
                if (log_we[k] != we) ok = 0;
                if (we && kind == 1 && log_data[k] != wd[8*k +: 8]) ok = 0;
                if (we && kind == 2 && log_data[k] != {7'b0, wd[k]}) ok = 0;
            end
            chk(ok, tag, "byte access sequence", 32'(log_addr[0]), 32'(base));
        end else if (kind == 3) begin
            chk(n_wacc == 1 && n_bacc == 0, tag, "word access count", 32'(n_wacc), 32'd1);
            chk(wlog_addr == base && wlog_we == we && (!we || wlog_data == wd), tag,
                "word access", 32'(wlog_addr), 32'(base));
        end else begin
            chk(n_bacc == 0 && n_wacc == 0, tag, "no access", 32'(n_bacc + n_wacc), 32'd0);
        end
        @(negedge clk);
        chk(!done && !busy, "R10", "done is single cycle", 32'({done, busy}), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(!busy && !done && !bp_en && !wp_en, "R1", "outputs in reset",
            32'({busy, done, bp_en, wp_en}), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !bp_en && !wp_en, "R1", "outputs after reset",
            32'({busy, done, bp_en, wp_en}), 32'd0);

        // directed corners
        do_txn(12'h000, 2'd0, 1'b0, 32'h0, 0);             // R2 control
        do_txn(12'h3FF, 2'd1, 1'b0, 32'h0, 0);             // R2 attribute, top select
        do_txn(12'h005, 2'd0, 1'b1, 32'hDEAD_BEEF, 0);     // R3
        do_txn(12'h005, 2'd0, 1'b0, 32'h0, 0);             // R3 read back
        do_txn(12'h3FF, 2'd1, 1'b1, 32'h1234_5678, 0);     // R3
        do_txn(12'h3FF, 2'd1, 1'b0, 32'h0, 0);
        do_txn(12'h400, 2'd1, 1'b0, 32'h0, 0);             // R4 enable
        do_txn(12'h47F, 2'd0, 1'b1, 32'hA5F0_0F5A, 0);     // R5
        do_txn(12'h47F, 2'd0, 1'b0, 32'h0, 0);             // R4 pending read back
        do_txn(12'h480, 2'd0, 1'b0, 32'h0, 0);             // R6
        do_txn(12'h49F, 2'd0, 1'b1, 32'hCAFE_F00D, 0);     // R6
        do_txn(12'h49F, 2'd0, 1'b0, 32'h0, 0);
        do_txn(12'h481, 2'd1, 1'b0, 32'h0, 0);             // R7
        do_txn(12'h481, 2'd1, 1'b1, 32'hFFFF_FFFF, 0);     // R7
        do_txn(12'h4A0, 2'd0, 1'b0, 32'h0, 0);             // R8 reserved
        do_txn(12'hFFF, 2'd0, 1'b1, 32'h1111_1111, 0);     // R8
        do_txn(12'h010, 2'd2, 1'b0, 32'h0, 0);             // R8 bad index
        do_txn(12'h410, 2'd3, 1'b1, 32'h2222_2222, 0);     // R8 bad index
        do_txn(12'h020, 2'd0, 1'b0, 32'h0, 1);             // R9 held request
        do_txn(12'h420, 2'd1, 1'b1, 32'h0F0F_1234, 1);     // R9 held request
        do_txn(12'h420, 2'd1, 1'b0, 32'h0, 0);

        // constrained random
        for (int i = 0; i < 150; i++) begin
            logic [11:0] s;
            logic [1:0]  x;
            int r;
            r = $urandom_range(0, 5);
            case (r)
                0, 1: s = 12'($urandom_range(0, 12'h3FF));
                2, 3: s = 12'($urandom_range(12'h400, 12'h47F));
                4:    s = 12'($urandom_range(12'h480, 12'h49F));
                default: s = 12'($urandom_range(12'h4A0, 12'hFFF));
            endcase
            x = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'($urandom_range(0, 1));
            do_txn(s, x, 1'($urandom_range(0, 1)), $urandom, (i % 10) == 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog expired actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule